// File: doc/BRIEF.md
# Selective SEC-DED Register File

This block is a small register file shared by several hardware threads, with error protection that is applied only where it is worth the energy. Each word is 32 bits wide. Only the upper half of a word is covered by a single-error-correct, double-error-detect code (a (22,16) extended Hamming code with six check bits). The lower half is stored and returned as it is. Check bits are produced only when the writing instruction is marked critical. They are not produced at all when a thread writes the same value already held in the same-numbered register of thread 0, which acts as the reference thread.

Each entry carries a small per-entry state that decides how a read treats it:

- **ENT_PLAIN**: unprotected, returned as stored.
- **ENT_CODED**: decoded and corrected on read.
- **ENT_DUP**: a copy of the reference thread, returned as stored and never checked.

The state moves on these transitions:

- **own write**: the entry takes ENT_DUP, ENT_CODED or ENT_PLAIN, in that priority, according to the duplicate match and the critical flag.
- **reference overwrite**: a thread-0 write to the same register index moves ENT_DUP to ENT_PLAIN.
- **reset**: every entry goes to ENT_PLAIN.

The read port is combinational. Writes commit on the rising clock edge. A test-only injection port flips chosen bits of a stored entry, so that the correction and detection paths can be exercised.

Top module: `sel_ecc_rf`

## Requirements
- R1: A synchronous active-high reset clears every entry's data, check bits and state. After reset, every entry reads as zero with both error flags low.
- R2: The read outputs follow the read address combinationally from the stored contents. A write commits at the rising edge, so a read of the entry being written in the same cycle returns the old contents, and the new value is returned from the next cycle on.
- R3: For an entry written by a critical, non-duplicate write, a single flipped bit in the protected field is corrected on read, with rd_sef=1 and rd_ded=0. The protected field is data bits 31..16 plus the six stored check bits.
- R4: For such an entry, two flipped bits in the protected field give rd_ded=1 and rd_sef=0, and rd_data returns the stored word unchanged.
- R5: Data bits 15..0 are never corrected. A flip there shows at rd_data and by itself leaves both flags low, even on a coded entry.
- R6: A non-critical write stores the word unprotected. Flips anywhere in it are returned as stored, with both flags low.
- R7: A write from thread 1..3 whose value equals the word currently stored in thread 0 at the same register index marks the entry as a duplicate, whatever its critical flag. Reads of a duplicate return the stored word with both flags low.
- R8: Writes from thread 0 are never marked duplicate, even when the value equals what that register already holds. A critical thread-0 write is always coded.
- R9: A thread-0 write to register r turns every duplicate entry at index r in the other threads into an unprotected entry. Those entries keep their stored data.
- R10: When inj_en is high, inj_mask is XORed into the stored entry (inj_tid, inj_rid) at the clock edge. Mask bits 31..0 hit the data and bits 37..32 hit check bits 5..0. The injection is ignored when a write targets the same entry in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_tid | input | 2 | Write thread index |
| wr_rid | input | 3 | Write register index |
| wr_data | input | 32 | Write value |
| wr_crit | input | 1 | Writing instruction is critical |
| rd_tid | input | 2 | Read thread index |
| rd_rid | input | 3 | Read register index |
| rd_data | output | 32 | Read value, corrected where the entry is coded |
| rd_sef | output | 1 | Single error found and corrected |
| rd_ded | output | 1 | Double error detected, data uncorrected |
| inj_en | input | 1 | Test-only error injection strobe |
| inj_tid | input | 2 | Injection thread index |
| inj_rid | input | 3 | Injection register index |
| inj_mask | input | 38 | Bits to flip: 31..0 data, 37..32 check bits |

## Verification
Single-bit flips are placed in upper data bits, in check bits and in low data bits. This separates true correction from pass-through of the unprotected half. Double flips in the protected field show detection without miscorrection. The same flips applied to non-critical and duplicate entries must come back raw and unflagged, which tells the three entry states apart at the ports. A randomized phase then mixes writes, which sometimes copy the reference thread's word to force duplicates, with reads and single-bit injections kept within two flips per coded entry. A behavioural model compares every read on every cycle.

// File: rtl/sel_ecc_pkg.sv
package sel_ecc_pkg;

    // Per-entry protection state.
    typedef enum logic [1:0] {
        ENT_PLAIN = 2'd0,
        ENT_CODED = 2'd1,
        ENT_DUP   = 2'd2
    } ent_mode_e;

    // Number of Hamming check bits for k data bits (overall parity excluded).
    function automatic int ham_bits(input int k);
        int r;
        r = 1;
        while ((1 << r) < (k + r + 1)) r++;
        return r;
    endfunction

endpackage

// File: rtl/sel_ecc_enc.sv
module sel_ecc_enc #(
    parameter int PROT_W = 16,
    parameter int HAM_W  = 5
) (
    input  logic [PROT_W-1:0] din,
    output logic [HAM_W:0]    chk
);
    localparam int CWL = PROT_W + HAM_W;

    always_comb begin
        logic [CWL:1]   cw;
        logic [HAM_W:1] hb;
        int k;
        cw = '0;
        hb = '0;
        k  = 0;
        // Scatter data into the non-power-of-two positions.
        for (int p = 1; p <= CWL; p++) begin
            if ((p & (p - 1)) != 0) begin
                cw[p] = din[k];
                k++;
            end
        end
        // Check bit i covers every position whose index has bit i set.
        for (int i = 0; i < HAM_W; i++) begin
            for (int p = 1; p <= CWL; p++) begin
                if (((p >> i) & 1) == 1) hb[i+1] = hb[i+1] ^ cw[p];
            end
        end
        // Bit 0 is the overall parity over data and Hamming bits.
        chk = {hb, (^din) ^ (^hb)};
    end

endmodule

// File: rtl/sel_ecc_dec.sv
module sel_ecc_dec #(
    parameter int PROT_W = 16,
    parameter int HAM_W  = 5
) (
    input  logic [PROT_W-1:0] din,
    input  logic [HAM_W:0]    chk,
    output logic [PROT_W-1:0] dout,
    output logic              sef,
    output logic              ded
);
    localparam int CWL = PROT_W + HAM_W;

    always_comb begin
        logic [CWL:1]   cw;
        logic [HAM_W-1:0] syn;
        logic par;
        int k;
        cw  = '0;
        syn = '0;
        k   = 0;
        for (int p = 1; p <= CWL; p++) begin
            if ((p & (p - 1)) != 0) begin
                cw[p] = din[k];
                k++;
            end
        end
        for (int i = 0; i < HAM_W; i++) cw[1 << i] = chk[i+1];
        for (int p = 1; p <= CWL; p++) begin
            if (cw[p]) syn = syn ^ HAM_W'(p);
        end
        par = (^cw) ^ chk[0];
        sef = 1'b0;
        ded = 1'b0;
        if (par) begin
            if (32'(syn) <= CWL) begin
                sef = 1'b1;
                if (syn != '0) cw[syn] = ~cw[syn];
            end else begin
                ded = 1'b1;
            end
        end else if (syn != '0) begin
            ded = 1'b1;
        end
        dout = '0;
        k    = 0;
        for (int p = 1; p <= CWL; p++) begin
            if ((p & (p - 1)) != 0) begin
                dout[k] = cw[p];
                k++;
            end
        end
    end

endmodule

// File: rtl/sel_ecc_store.sv
module sel_ecc_store
    import sel_ecc_pkg::*;
#(
    parameter int THREADS = 4,
    parameter int REGS    = 8,
    parameter int DATA_W  = 32,
    parameter int CHK_W   = 6,
    parameter int TID_W   = $clog2(THREADS),
    parameter int RID_W   = $clog2(REGS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [TID_W-1:0]        wr_tid,
    input  logic [RID_W-1:0]        wr_rid,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic                    wr_crit,
    input  logic [CHK_W-1:0]        wr_chk,
    input  logic                    inj_en,
    input  logic [TID_W-1:0]        inj_tid,
    input  logic [RID_W-1:0]        inj_rid,
    input  logic [DATA_W+CHK_W-1:0] inj_mask,
    input  logic [TID_W-1:0]        rd_tid,
    input  logic [RID_W-1:0]        rd_rid,
    output logic [DATA_W-1:0]       rd_word,
    output logic [CHK_W-1:0]        rd_chk,
    output ent_mode_e               rd_mode,
    output logic                    wr_dup
);
    logic [DATA_W-1:0] data_q [THREADS][REGS];
    logic [CHK_W-1:0]  chk_q  [THREADS][REGS];
    ent_mode_e         mode_q [THREADS][REGS];
    ent_mode_e         mode_d [THREADS][REGS];
    ent_mode_e         wr_cls;

    // Duplicate match against the reference thread's stored word.
    assign wr_dup = (wr_tid != '0) && (wr_data == data_q[0][wr_rid]);
    assign wr_cls = wr_dup ? ENT_DUP : (wr_crit ? ENT_CODED : ENT_PLAIN);

    // Next-state logic for every entry.
    always_comb begin
        for (int t = 0; t < THREADS; t++) begin
            for (int r = 0; r < REGS; r++) begin
                logic own_wr;
                logic ref_wr;
                own_wr = wr_en && (wr_tid == TID_W'(t)) && (wr_rid == RID_W'(r));
                ref_wr = wr_en && (wr_tid == '0) && (wr_rid == RID_W'(r)) && (t != 0);
                unique case (mode_q[t][r])
                    ENT_PLAIN, ENT_CODED: mode_d[t][r] = own_wr ? wr_cls : mode_q[t][r];
                    ENT_DUP:   mode_d[t][r] = own_wr ? wr_cls :
                                              (ref_wr ? ENT_PLAIN : ENT_DUP);
                    default:   mode_d[t][r] = ENT_PLAIN;
                endcase
            end
        end
    end

    // State register and storage.
    always_ff @(posedge clk) begin
        for (int t = 0; t < THREADS; t++) begin
            for (int r = 0; r < REGS; r++) begin
                if (rst) begin
                    data_q[t][r] <= '0;
                    chk_q[t][r]  <= '0;
                    mode_q[t][r] <= ENT_PLAIN;
                end else begin
                    mode_q[t][r] <= mode_d[t][r];
                    if (wr_en && (wr_tid == TID_W'(t)) && (wr_rid == RID_W'(r))) begin
                        data_q[t][r] <= wr_data;
                        chk_q[t][r]  <= (wr_cls == ENT_CODED) ? wr_chk : '0;
                    end else if (inj_en && (inj_tid == TID_W'(t)) && (inj_rid == RID_W'(r))) begin
                        data_q[t][r] <= data_q[t][r] ^ inj_mask[DATA_W-1:0];
                        chk_q[t][r]  <= chk_q[t][r] ^ inj_mask[DATA_W+CHK_W-1:DATA_W];
                    end
                end
            end
        end
    end

    assign rd_word = data_q[rd_tid][rd_rid];
    assign rd_chk  = chk_q[rd_tid][rd_rid];
    assign rd_mode = mode_q[rd_tid][rd_rid];

endmodule

// File: rtl/sel_ecc_rf.sv
module sel_ecc_rf
    import sel_ecc_pkg::*;
#(
    parameter int THREADS = 4,
    parameter int REGS    = 8,
    parameter int DATA_W  = 32,
    parameter int PROT_W  = 16,
    localparam int TID_W  = $clog2(THREADS),
    localparam int RID_W  = $clog2(REGS),
    localparam int HAM_W  = ham_bits(PROT_W),
    localparam int CHK_W  = HAM_W + 1,
    localparam int LOW_W  = DATA_W - PROT_W,
    localparam int INJ_W  = DATA_W + CHK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [TID_W-1:0]  wr_tid,
    input  logic [RID_W-1:0]  wr_rid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_crit,
    input  logic [TID_W-1:0]  rd_tid,
    input  logic [RID_W-1:0]  rd_rid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_sef,
    output logic              rd_ded,
    input  logic              inj_en,
    input  logic [TID_W-1:0]  inj_tid,
    input  logic [RID_W-1:0]  inj_rid,
    input  logic [INJ_W-1:0]  inj_mask
);
    logic [CHK_W-1:0]  enc_chk;
    logic [DATA_W-1:0] rd_word;
    logic [CHK_W-1:0]  rd_chk;
    ent_mode_e         rd_mode;
    logic              wr_dup;
    logic [PROT_W-1:0] dec_hi;
    logic              dec_sef;
    logic              dec_ded;

    sel_ecc_enc #(.PROT_W(PROT_W), .HAM_W(HAM_W)) u_enc (
        .din (wr_data[DATA_W-1:LOW_W]),
        .chk (enc_chk)
    );

    sel_ecc_store #(
        .THREADS(THREADS), .REGS(REGS), .DATA_W(DATA_W), .CHK_W(CHK_W),
        .TID_W(TID_W), .RID_W(RID_W)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_tid   (wr_tid),
        .wr_rid   (wr_rid),
        .wr_data  (wr_data),
        .wr_crit  (wr_crit),
        .wr_chk   (enc_chk),
        .inj_en   (inj_en),
        .inj_tid  (inj_tid),
        .inj_rid  (inj_rid),
        .inj_mask (inj_mask),
        .rd_tid   (rd_tid),
        .rd_rid   (rd_rid),
        .rd_word  (rd_word),
        .rd_chk   (rd_chk),
        .rd_mode  (rd_mode),
        .wr_dup   (wr_dup)
    );

    sel_ecc_dec #(.PROT_W(PROT_W), .HAM_W(HAM_W)) u_dec (
        .din  (rd_word[DATA_W-1:LOW_W]),
        .chk  (rd_chk),
        .dout (dec_hi),
        .sef  (dec_sef),
        .ded  (dec_ded)
    );

    // Output process: only coded entries go through the decoder.
    always_comb begin
        unique case (rd_mode)
            ENT_CODED: begin
                rd_data = {dec_hi, rd_word[LOW_W-1:0]};
                rd_sef  = dec_sef;
                rd_ded  = dec_ded;
            end
            ENT_PLAIN, ENT_DUP: begin
                rd_data = rd_word;
                rd_sef  = 1'b0;
                rd_ded  = 1'b0;
            end
            default: begin
                rd_data = rd_word;
                rd_sef  = 1'b0;
                rd_ded  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sel_ecc_rf_chk.sv
module sel_ecc_rf_chk #(
    parameter int DATA_W = 32,
    parameter int PROT_W = 16,
    parameter int TID_W  = 2,
    parameter int RID_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [TID_W-1:0]  wr_tid,
    input logic [RID_W-1:0]  wr_rid,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_dup,
    input logic [TID_W-1:0]  rd_tid,
    input logic [RID_W-1:0]  rd_rid,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_sef,
    input logic              rd_ded,
    input logic [DATA_W-1:0] rd_word,
    input logic [1:0]        rd_mode
);
    localparam int LOW_W = DATA_W - PROT_W;

    // R1: the cycle after reset, the read port shows a cleared entry.
    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (rd_data == '0) && !rd_sef && !rd_ded);

    // R2: a committed write is read back intact on the next cycle.
    p_write_visible_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en) && (rd_tid == $past(wr_tid)) && (rd_rid == $past(wr_rid)))
        |-> (rd_data == $past(wr_data)) && !rd_sef && !rd_ded);

    // R4: the two flags never assert together.
    p_flags_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
        !(rd_sef && rd_ded));

    // R5: the low half leaves the read port exactly as stored.
    p_low_passthru_r5: assert property (@(posedge clk) disable iff (rst)
        rd_data[LOW_W-1:0] == rd_word[LOW_W-1:0]);

    // R6: entries that are not coded never raise a flag.
    p_uncoded_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_mode != sel_ecc_pkg::ENT_CODED) |-> (!rd_sef && !rd_ded));

    // R7: a matching write from another thread lands as a duplicate.
    p_dup_marked_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en && wr_dup) && (rd_tid == $past(wr_tid)) && (rd_rid == $past(wr_rid)))
        |-> (rd_mode == sel_ecc_pkg::ENT_DUP));

    // R8: reference-thread entries are never duplicates.
    p_ref_not_dup_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_tid == '0) |-> (rd_mode != sel_ecc_pkg::ENT_DUP));

    // R9: after a reference write, the same index elsewhere is not a duplicate.
    p_ref_clears_dup_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en && (wr_tid == '0)) && (rd_rid == $past(wr_rid))
         && (rd_tid != '0) && !(($past(wr_tid) == rd_tid)))
        |-> (rd_mode != sel_ecc_pkg::ENT_DUP));

endmodule

bind sel_ecc_rf sel_ecc_rf_chk #(
    .DATA_W(DATA_W), .PROT_W(PROT_W), .TID_W(TID_W), .RID_W(RID_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_tid  (wr_tid),
    .wr_rid  (wr_rid),
    .wr_data (wr_data),
    .wr_dup  (wr_dup),
    .rd_tid  (rd_tid),
    .rd_rid  (rd_rid),
    .rd_data (rd_data),
    .rd_sef  (rd_sef),
    .rd_ded  (rd_ded),
    .rd_word (rd_word),
    .rd_mode (rd_mode)
);

// File: tb/sel_ecc_rf_bench.sv
module sel_ecc_rf_bench;
    localparam int CLK_P = 10;
    localparam int NT = 4;
    localparam int NR = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_tid = '0;
    logic [2:0]  wr_rid = '0;
    logic [31:0] wr_data = '0;
    logic        wr_crit = 1'b0;
    logic [1:0]  rd_tid = '0;
    logic [2:0]  rd_rid = '0;
    logic [31:0] rd_data;
    logic        rd_sef;
    logic        rd_ded;
    logic        inj_en = 1'b0;
    logic [1:0]  inj_tid = '0;
    logic [2:0]  inj_rid = '0;
    logic [37:0] inj_mask = '0;

    sel_ecc_rf u_sel_ecc_rf (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_tid(wr_tid), .wr_rid(wr_rid),
        .wr_data(wr_data), .wr_crit(wr_crit), .rd_tid(rd_tid), .rd_rid(rd_rid),
        .rd_data(rd_data), .rd_sef(rd_sef), .rd_ded(rd_ded), .inj_en(inj_en),
        .inj_tid(inj_tid), .inj_rid(inj_rid), .inj_mask(inj_mask)
    );

    always #(CLK_P/2) clk = ~clk;

    // Behavioural model: intended word, accumulated flips, entry class
    // (0 unprotected, 1 coded, 2 duplicate).
    logic [31:0] gold [NT][NR];
    logic [31:0] dflip[NT][NR];
    logic [5:0]  cflip[NT][NR];
    int          cls  [NT][NR];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    function automatic int prot_flips(int t, int r);
        return $countones(dflip[t][r][31:16]) + $countones(cflip[t][r]);
    endfunction

    task automatic expect_read(input int t, input int r, output logic [31:0] d,
                               output logic s, output logic e, output string tg);
        logic [31:0] st;
        int n;
        st = gold[t][r] ^ dflip[t][r];
        s = 1'b0; e = 1'b0; d = st;
        if (cls[t][r] == 2) tg = "R7";
        else if (cls[t][r] == 0) tg = "R6";
        else begin
            n = prot_flips(t, r);
            if (n == 1) begin
                d = gold[t][r] ^ {16'h0, dflip[t][r][15:0]};
                s = 1'b1; tg = "R3";
            end else if (n >= 2) begin
                e = 1'b1; tg = "R4";
            end else tg = (dflip[t][r][15:0] != 0) ? "R5" : "R2";
        end
    endtask

    // One clock: drive at the falling edge, check the read, then update the model.
    task automatic step(input bit we, input int wt, input int wr, input logic [31:0] wd,
                        input bit wc, input int rt, input int rr, input bit ie,
                        input int it, input int ir, input logic [37:0] im, input string tag);
        logic [31:0] ed;
        logic es, ee;
        string tg;
        bit dupf;
        wr_en = we; wr_tid = 2'(wt); wr_rid = 3'(wr); wr_data = wd; wr_crit = wc;
        rd_tid = 2'(rt); rd_rid = 3'(rr);
        inj_en = ie; inj_tid = 2'(it); inj_rid = 3'(ir); inj_mask = im;
        #1;
        expect_read(rt, rr, ed, es, ee, tg);
        if (tag != "") tg = tag;
        n_chk++;
        if (rd_data !== ed || rd_sef !== es || rd_ded !== ee) begin
            n_fail++;
            $display("FAIL %s t%0d r%0d: actual data=%h sef=%b ded=%b expected data=%h sef=%b ded=%b",
                     tg, rt, rr, rd_data, rd_sef, rd_ded, ed, es, ee);
        end
        @(posedge clk);
        if (we) begin
            dupf = (wt != 0) && (wd == (gold[0][wr] ^ dflip[0][wr]));
            if (wt == 0) for (int t = 1; t < NT; t++) if (cls[t][wr] == 2) cls[t][wr] = 0;
            gold[wt][wr] = wd; dflip[wt][wr] = '0; cflip[wt][wr] = '0;
            cls[wt][wr] = dupf ? 2 : (wc ? 1 : 0);
        end
        if (ie && !(we && wt == it && wr == ir)) begin
            dflip[it][ir] = dflip[it][ir] ^ im[31:0];
            cflip[it][ir] = cflip[it][ir] ^ im[37:32];
        end
        @(negedge clk);
    endtask

    task automatic wr_op(int t, int r, logic [31:0] d, bit c, string tag);
        step(1, t, r, d, c, t, r, 0, 0, 0, '0, tag);
    endtask
    task automatic rd_op(int t, int r, string tag);
        step(0, 0, 0, '0, 0, t, r, 0, 0, 0, '0, tag);
    endtask
    task automatic inj_op(int t, int r, logic [37:0] m, string tag);
        step(0, 0, 0, '0, 0, t, r, 1, t, r, m, tag);
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R2 watchdog: actual=not finished expected=finished");
            finish_run();
        end
    end

    initial begin
        for (int t = 0; t < NT; t++)
            for (int r = 0; r < NR; r++) begin
                gold[t][r] = '0; dflip[t][r] = '0; cflip[t][r] = '0; cls[t][r] = 0;
            end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: every entry cleared.
        for (int t = 0; t < NT; t++)
            for (int r = 0; r < NR; r++) rd_op(t, r, "R1");

        // R2: same-cycle read shows old contents, next cycle shows the new word.
        wr_op(0, 3, 32'hA5C3_1E7F, 1, "R2");
        rd_op(0, 3, "R2");
        // R3: single flip in an upper data bit is corrected.
        inj_op(0, 3, 38'h1 << 20, "R10");
        rd_op(0, 3, "R3");
        // R3: single flip in a check bit leaves data intact and is flagged.
        wr_op(0, 4, 32'h1234_5678, 1, "R2");
        inj_op(0, 4, 38'h1 << 35, "R10");
        rd_op(0, 4, "R3");
        // R4: double flip is detected, data returned raw.
        wr_op(0, 5, 32'hFFFF_0000, 1, "R2");
        inj_op(0, 5, (38'h1 << 17) | (38'h1 << 30), "R10");
        rd_op(0, 5, "R4");
        // R4: data bit plus check bit.
        wr_op(1, 0, 32'h0F0F_F0F0, 1, "R2");
        inj_op(1, 0, (38'h1 << 16) | (38'h1 << 32), "R10");
        rd_op(1, 0, "R4");
        // R5: low-half flips pass through, unflagged, then combine with a corrected one.
        wr_op(0, 6, 32'hDEAD_BEEF, 1, "R2");
        inj_op(0, 6, (38'h1 << 2) | (38'h1 << 9), "R10");
        rd_op(0, 6, "R5");
        inj_op(0, 6, 38'h1 << 25, "R10");
        rd_op(0, 6, "R5");
        // R6: non-critical entry returns flips raw.
        wr_op(1, 1, 32'h7654_3210, 0, "R6");
        inj_op(1, 1, 38'h1 << 28, "R10");
        rd_op(1, 1, "R6");
        // R7: duplicates of the reference word, critical or not.
        wr_op(0, 2, 32'hCAFE_F00D, 1, "R2");
        wr_op(2, 2, 32'hCAFE_F00D, 1, "R7");
        wr_op(3, 2, 32'hCAFE_F00D, 0, "R7");
        inj_op(2, 2, 38'h1 << 31, "R10");
        rd_op(2, 2, "R7");
        inj_op(3, 2, 38'h1 << 36, "R10");
        rd_op(3, 2, "R7");
        // R8: thread 0 rewriting its own value stays coded.
        wr_op(0, 7, 32'h8000_0001, 1, "R8");
        wr_op(0, 7, 32'h8000_0001, 1, "R8");
        inj_op(0, 7, 38'h1 << 19, "R10");
        rd_op(0, 7, "R8");
        // R9: reference overwrite drops the duplicate, data kept.
        wr_op(0, 2, 32'h0BAD_CAFE, 1, "R9");
        rd_op(2, 2, "R9");
        rd_op(3, 2, "R9");
        wr_op(1, 2, 32'h0BAD_CAFE, 0, "R7");
        inj_op(1, 2, 38'h1 << 21, "R10");
        rd_op(1, 2, "R7");
        // R10: injection on the entry being written is dropped.
        step(1, 1, 5, 32'h1357_9BDF, 1, 1, 5, 1, 1, 5, 38'h1 << 20, "R10");
        rd_op(1, 5, "R10");
        // R10: injection on another entry in the same cycle still lands.
        step(1, 2, 6, 32'h2468_ACE0, 1, 2, 6, 1, 3, 6, 38'h1 << 18, "R10");
        rd_op(2, 6, "R10");
        rd_op(3, 6, "R10");

        // Randomized mix, checked every cycle against the model.
        for (int i = 0; i < 3000; i++) begin
            int wt, wr, rt, rr, it, ir;
            bit we, wc, ie;
            logic [31:0] wd;
            logic [37:0] im;
            we = ($urandom % 3) == 0;
            wt = $urandom % NT; wr = $urandom % NR;
            wc = $urandom % 2;
            wd = (($urandom % 4) == 0) ? (gold[0][wr] ^ dflip[0][wr]) : $urandom;
            rt = $urandom % NT; rr = $urandom % NR;
            it = $urandom % NT; ir = $urandom % NR;
            im = 38'h1 << ($urandom % 38);
            ie = (($urandom % 4) == 0) && (cls[it][ir] != 1 || prot_flips(it, ir) < 2);
            step(we, wt, wr, wd, wc, rt, rr, ie, it, ir, im, "");
        end

        finish_run();
    end

endmodule